// File: doc/BRIEF.md
# Extended Memory Bank Register

This block sits on the processor bus of an 8-bit machine whose memory already switches four 16 KB banks into the window from 0x4000 to 0x7FFF, using bank bits on port B of a peripheral adapter. The adapter decodes only two address bits. Its four registers therefore repeat across the whole of page 0xD3. The block claims one location in that page, 0xD3FF, by decoding all sixteen address bits. At that location it holds an 8-bit value that the processor can both write and read.

Whenever the bus addresses 0xD3FF, the block pulls the adapter's extra active-high select low, so the adapter ignores the cycle. Every other address in page 0xD3 still reaches the adapter. The stored byte is placed above the two legacy bank bits to form a 10-bit bank number, which gives 1024 banks of 16 KB each (16 MB in total). When the byte is zero, the bank number equals the legacy 2-bit bank, so the machine behaves exactly like the stock 4-bank design. Boot firmware that writes 0x00 across page 0xD3 clears the byte as a side effect. This returns bank selection to zero and leaves the memory contents alone.

Top module: `xbank_reg`

## Requirements
- R1: When `rst_ni` is low, the register is cleared to 0x00. With a cleared register, `bank_o[9:2]` is 0.
- R2: `pia_cs_o` is 0 exactly when `addr_i` is 0xD3FF and is 1 for every other address, including other 0xD3xx offsets (such as 0xD303 and 0xD3FE) and 0xFF offsets in other pages.
- R3: A write cycle (`rw_i`=0) to 0xD3FF loads `data_i` into the register at the first `clk_i` edge that sees `phi2_i` low after it was high. Writes to any other address leave the register unchanged.
- R4: `data_oe_o` is 1 only while `rw_i`=1, `phi2_i`=1 and `addr_i` is 0xD3FF. While it is 1, `data_o` carries the register value.
- R5: `bank_o` equals {register, `portb_i[3:2]`}. Bits 3:2 of port B are the legacy bank bits, and the register forms the upper 8 bits.
- R6: `ext_sel_o` is 1 exactly when `portb_i[4]` is 0 (legacy extended-access enable, active low) and `addr_i[15:14]` is 2'b01, that is, the address lies from 0x4000 to 0x7FFF.
- R7: With the register at 0x00, `bank_o` equals the 2-bit legacy bank for every value of `portb_i[3:2]`.
- R8: A sweep that writes 0x00 to every address from 0xD300 to 0xD3FF leaves the register at 0x00.
- R9: A read cycle at 0xD3FF does not change the register, whatever value is on `data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address |
| data_i | input | 8 | Processor write data |
| rw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2_i | input | 1 | Bus phase-2 clock level |
| portb_i | input | 8 | Adapter port B outputs |
| data_o | output | 8 | Read-back data |
| data_oe_o | output | 1 | Drive enable for read-back data |
| pia_cs_o | output | 1 | Extra active-high select to the adapter |
| bank_o | output | 10 | Extended bank number |
| ext_sel_o | output | 1 | Extended window access in progress |

## Verification
The assertions assume a 6502-style bus: address, `rw_i` and write data are stable while `phi2_i` is high and across the clock edge that sees its falling edge, and `phi2_i` stays at each level for at least one clock. The bench drives every bus cycle through one task. That task sets the address and data on a falling clock edge with phase 2 low, raises phase 2 for one clock period, lowers it, and holds the bus for one more edge before releasing it. As a result, every capture edge sees settled inputs.

// File: rtl/xbank_pkg.sv
package xbank_pkg;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned LEG_W   = 2;
  localparam int unsigned LEG_LSB = 2;
  localparam int unsigned EN_BIT  = 4;
  localparam logic [7:0]  REG_PAGE = 8'hD3;
  localparam logic [7:0]  REG_OFF  = 8'hFF;
  localparam logic [1:0]  WIN_TAG  = 2'b01;

  typedef struct packed {
    logic page_hit;
    logic reg_hit;
  } dec_t;
endpackage

// File: rtl/xbank_decode.sv
module xbank_decode
  import xbank_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter logic [7:0]  PAGE     = REG_PAGE,
  parameter logic [7:0]  OFFSET   = REG_OFF
) (
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  localparam int unsigned PW = AW - 8;
  logic [7:0] low_match;

  // full decode of the low byte, bit by bit
  for (genvar b = 0; b < 8; b++) begin : g_low
    assign low_match[b] = ~(addr_i[b] ^ OFFSET[b]);
  end

  always_comb begin
    dec_o.page_hit = (addr_i[AW-1 -: PW] == PW'(PAGE));
    dec_o.reg_hit  = dec_o.page_hit & (&low_match);
  end
endmodule

// File: rtl/xbank_store.sv
module xbank_store #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phi2_i,
  input  logic          wr_hit_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] q_o
);
  logic phi2_q;
  logic phi2_fall;

  assign phi2_fall = phi2_q & ~phi2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phi2_q <= 1'b0;
      q_o    <= '0;
    end else begin
      phi2_q <= phi2_i;
      if (phi2_fall && wr_hit_i) q_o <= data_i;
    end
  end
endmodule

// File: rtl/xbank_map.sv
module xbank_map #(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned LW     = 2,
  parameter int unsigned LSB    = 2,
  parameter int unsigned EN     = 4,
  parameter logic [1:0]  WIN    = 2'b01
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       portb_i,
  input  logic [DW-1:0]    reg_i,
  output logic [DW+LW-1:0] bank_o,
  output logic             ext_sel_o
);
  assign bank_o    = {reg_i, portb_i[LSB +: LW]};
  // enable bit is active low on the legacy port
  assign ext_sel_o = ~portb_i[EN] & (addr_i[AW-1 -: 2] == WIN);
endmodule

// File: rtl/xbank_reg.sv
module xbank_reg
  import xbank_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned LW  = LEG_W,
  localparam int unsigned BW = DW + LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          rw_i,
  input  logic          phi2_i,
  input  logic [7:0]    portb_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          pia_cs_o,
  output logic [BW-1:0] bank_o,
  output logic          ext_sel_o
);
  dec_t          dec;
  logic [DW-1:0] reg_q;

  xbank_decode #(.AW(AW), .PAGE(REG_PAGE), .OFFSET(REG_OFF)) u_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  xbank_store #(.DW(DW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .phi2_i   (phi2_i),
    .wr_hit_i (dec.reg_hit & ~rw_i),
    .data_i   (data_i),
    .q_o      (reg_q)
  );

  xbank_map #(.AW(AW), .DW(DW), .LW(LW), .LSB(LEG_LSB), .EN(EN_BIT), .WIN(WIN_TAG)) u_map (
    .addr_i    (addr_i),
    .portb_i   (portb_i),
    .reg_i     (reg_q),
    .bank_o    (bank_o),
    .ext_sel_o (ext_sel_o)
  );

  assign pia_cs_o  = ~dec.reg_hit;
  assign data_oe_o = dec.reg_hit & rw_i & phi2_i;
  assign data_o    = reg_q;
endmodule

// File: rtl/xbank_reg_chk.sv
module xbank_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  data_i,
  input logic        rw_i,
  input logic        phi2_i,
  input logic [7:0]  portb_i,
  input logic [7:0]  data_o,
  input logic        data_oe_o,
  input logic        pia_cs_o,
  input logic [9:0]  bank_o,
  input logic        ext_sel_o
);
  logic phi2_d;
  logic at_reg;
  logic cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phi2_d <= 1'b0;
    else         phi2_d <= phi2_i;
  end

  assign at_reg = (addr_i == 16'hD3FF);
  assign cap    = phi2_d & ~phi2_i & at_reg & ~rw_i;

  p_other_page_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:8] != 8'hD3) |-> pia_cs_o);

  p_reg_deselect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_reg |-> !pia_cs_o);

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (bank_o[9:2] == $past(data_i)));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(bank_o[9:2]));

  p_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (rw_i && phi2_i && !pia_cs_o && data_o == bank_o[9:2]));

  p_legacy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_o[1:0] == portb_i[3:2]);

  p_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_sel_o |-> (!portb_i[4] && addr_i[15:14] == 2'b01));
endmodule

bind xbank_reg xbank_reg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .data_i    (data_i),
  .rw_i      (rw_i),
  .phi2_i    (phi2_i),
  .portb_i   (portb_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .pia_cs_o  (pia_cs_o),
  .bank_o    (bank_o),
  .ext_sel_o (ext_sel_o)
);

// File: tb/sim_xbank_reg.sv
`timescale 1ns/1ps
module sim_xbank_reg;
  typedef enum logic [2:0] {K_BANK, K_CS, K_OE, K_DOUT, K_EXT} kind_e;
  typedef struct {
    kind_e      k;
    logic [9:0] v;
    string      req;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = 16'h0000;
  logic [7:0]  data_i = 8'h00;
  logic        rw_i = 1'b1;
  logic        phi2_i = 1'b0;
  logic [7:0]  portb_i = 8'hFF;
  logic [7:0]  data_o;
  logic        data_oe_o;
  logic        pia_cs_o;
  logic [9:0]  bank_o;
  logic        ext_sel_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic [7:0] model = 8'h00;
  exp_t q[$];

  always #2.5 clk_i = ~clk_i;

  xbank_reg u0 (.*);

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      exp_t e;
      logic [9:0] obs;
      wait (q.size() != 0);
      e = q.pop_front();
      case (e.k)
        K_BANK:  obs = bank_o;
        K_CS:    obs = {9'd0, pia_cs_o};
        K_OE:    obs = {9'd0, data_oe_o};
        K_DOUT:  obs = {2'd0, data_o};
        default: obs = {9'd0, ext_sel_o};
      endcase
      checks++;
      if (obs !== e.v) begin
        errors++;
        $display("FAIL %s kind=%s actual=%h expected=%h", e.req, e.k.name(), obs, e.v);
      end
    end
  end

  task automatic expect_val(input kind_e k, input logic [9:0] v, input string req);
    exp_t e;
    e.k = k; e.v = v; e.req = req;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  task automatic exp_bank(input string req);
    expect_val(K_BANK, {model, portb_i[3:2]}, req);
  endtask

  task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; rw_i = 1'b0; phi2_i = 1'b0;
    @(negedge clk_i); phi2_i = 1'b1;
    @(negedge clk_i); phi2_i = 1'b0;
    @(negedge clk_i); rw_i = 1'b1; addr_i = 16'h0000;
    if (a == 16'hD3FF) model = d;
  endtask

  task automatic rd_cycle(input logic [15:0] a, input logic [7:0] junk,
                          input logic oe_exp, input string req);
    @(negedge clk_i);
    addr_i = a; data_i = junk; rw_i = 1'b1; phi2_i = 1'b0;
    @(negedge clk_i);
    expect_val(K_OE, 10'd0, req);
    phi2_i = 1'b1;
    @(negedge clk_i);
    expect_val(K_OE, {9'd0, oe_exp}, req);
    if (oe_exp) expect_val(K_DOUT, {2'd0, model}, req);
    phi2_i = 1'b0;
    @(negedge clk_i); addr_i = 16'h0000;
  endtask

  task automatic cs_at(input logic [15:0] a, input logic v, input string req);
    @(negedge clk_i); addr_i = a;
    #1 expect_val(K_CS, {9'd0, v}, req);
  endtask

  task automatic ext_at(input logic [15:0] a, input logic [7:0] pb, input logic v, input string req);
    @(negedge clk_i); addr_i = a; portb_i = pb;
    #1 expect_val(K_EXT, {9'd0, v}, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    expect_val(K_BANK, 10'h003, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    exp_bank("R1 after reset");

    // R2 decode of the extra adapter select
    cs_at(16'hD3FF, 1'b0, "R2 reg addr");
    cs_at(16'hD303, 1'b1, "R2 mirror D303");
    cs_at(16'hD3FE, 1'b1, "R2 D3FE");
    cs_at(16'hD2FF, 1'b1, "R2 other page");
    cs_at(16'h53FF, 1'b1, "R2 high bit differs");
    cs_at(16'hD37F, 1'b1, "R2 bit7 low");

    // R3 capture and ignored writes
    wr_cycle(16'hD3FF, 8'hA5);
    exp_bank("R3 write A5");
    wr_cycle(16'hD303, 8'h3C);
    exp_bank("R3 mirror write ignored");
    wr_cycle(16'hC3FF, 8'h3C);
    exp_bank("R3 other page write ignored");
    wr_cycle(16'hD3FF, 8'h01);
    exp_bank("R3 write 01");

    // R4 read back, R9 no effect of read
    rd_cycle(16'hD3FF, 8'hEE, 1'b1, "R4 read reg");
    rd_cycle(16'hD301, 8'hEE, 1'b0, "R4 mirror read not driven");
    wr_cycle(16'hD3FF, 8'h5A);
    rd_cycle(16'hD3FF, 8'hFF, 1'b1, "R9 read path");
    exp_bank("R9 register unchanged by read");

    // R5 legacy bits under the register
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); portb_i = {4'b1110, i[1:0], 2'b11};
      #1 exp_bank("R5 legacy bits");
    end

    // R6 window gating
    ext_at(16'h4000, 8'hEF, 1'b1, "R6 window low edge");
    ext_at(16'h7FFF, 8'hEF, 1'b1, "R6 window high edge");
    ext_at(16'h3FFF, 8'hEF, 1'b0, "R6 below window");
    ext_at(16'h8000, 8'hEF, 1'b0, "R6 above window");
    ext_at(16'h5000, 8'hFF, 1'b0, "R6 enable off");

    // R7 stock behaviour with register at zero
    wr_cycle(16'hD3FF, 8'h00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); portb_i = {4'b1110, i[1:0], 2'b01};
      #1 expect_val(K_BANK, {8'h00, i[1:0]}, "R7 stock bank");
    end

    // R8 cold start sweep clears the register
    wr_cycle(16'hD3FF, 8'hC3);
    exp_bank("R8 preset");
    for (int a = 0; a < 256; a++) wr_cycle(16'hD300 | 16'(a), 8'h00);
    exp_bank("R8 after sweep");
    expect_val(K_BANK, {8'h00, portb_i[3:2]}, "R8 zero");

    // R1 reset in mid run
    wr_cycle(16'hD3FF, 8'h77);
    @(negedge clk_i); rst_ni = 1'b0; model = 8'h00;
    #1 exp_bank("R1 mid-run reset");
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); exp_bank("R1 after release");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule